// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Front End

This block is the processor-facing register file of a PC-style serial port, reduced to what software can see. A host drives single-cycle reads and writes over a 3-bit address and an 8-bit data bus. Eight offsets reach line control, interrupt enable, modem control, scratch and a 16-bit baud divisor. The divisor shares offsets 0 and 1 with the data and interrupt-enable registers. Serial bit timing and modem pins are not modelled. The transmitter always reports idle and empty. A byte written for transmission leaves at once on a byte stream output.

Received bytes come from an external producer over a valid/ready interface into a 16-entry FIFO. Software drains the FIFO by reading offset 0 and polls line status for data-ready and overrun. It may enable a one-cycle interrupt pulse that fires for each accepted byte.

The identification register at offset 2 is a two-state machine. In state IDENT_ODD it reads 0x01, and in state IDENT_EVEN it reads 0x00. Every read of offset 2 takes the transition IDENT_ODD -> IDENT_EVEN or IDENT_EVEN -> IDENT_ODD. Reset enters IDENT_ODD.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, the line control, interrupt enable, modem control, scratch and divisor registers read 0. Offset 2 reads 0x01, offset 5 reads 0x60, rx_ready is 1, and tx_valid and irq are 0.
- R2: Bit 7 of the line control register (offset 3, read/write) is the divisor-access bit. While it is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. Such writes produce no transmit output.
- R3: While the divisor-access bit is 0, a write to offset 0 with data other than 0xFF raises tx_valid for exactly the next cycle, with tx_data equal to the written byte. A written 0xFF produces no output.
- R4: While the divisor-access bit is 0, offset 1 reads and writes the interrupt enable register.
- R5: While the divisor-access bit is 0, a read of offset 0 returns the oldest received byte and removes it, so bytes leave in arrival order. A read with the FIFO empty returns 0xFF and changes nothing.
- R6: Line status (offset 5) always has bits 5 and 6 set. Bit 0 is 1 exactly when the receive FIFO holds at least one byte. Bits 7, 4, 3 and 2 are 0.
- R7: The receive FIFO holds 16 bytes, and rx_ready is 0 exactly when it is full. A byte offered while the FIFO is full is dropped and sets line status bit 1. That bit stays set until line status is read, and the read that clears it still returns 1 in bit 1.
- R8: Each read of offset 2 returns the current identification value and then toggles its bit 0. Its other bits read 0.
- R9: irq is a one-cycle pulse, in the cycle after a byte is accepted into the FIFO, when interrupt enable bit 0 is 1. Dropped bytes and disabled interrupts give no pulse.
- R10: Writes to offsets 2, 5 and 6 change nothing that can be read. Offset 6 (modem status) always reads 0.
- R11: Offset 4 (modem control) and offset 7 (scratch) are plain 8-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| rx_valid | input | 1 | Producer offers a received byte |
| rx_data | input | 8 | Offered byte |
| rx_ready | output | 1 | FIFO can accept a byte |
| tx_valid | output | 1 | Transmit byte present, one cycle |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Receive interrupt pulse |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle, and that a register read and a byte push never both aim at the overrun flag in one cycle. The bench drives one operation per cycle: a read, a write or a push, never two at once. Its random mix draws addresses, data and push values from a seeded generator. That mix keeps the FIFO cycling through empty, partly full and full, and lets random line control writes switch divisor access on and off. Directed sequences cover the reset values, the 0xFF drop, the full-FIFO overrun and its clearing read, and reads of an empty FIFO.

// File: rtl/serial_port_regs_pkg.sv
package serial_port_regs_pkg;

    localparam int BYTE_W = 8;

    // Register offsets on the byte bus
    typedef enum logic [2:0] {
        OFS_HOLD      = 3'd0,
        OFS_IEN       = 3'd1,
        OFS_IDENT     = 3'd2,
        OFS_LINECTL   = 3'd3,
        OFS_MODEMCTL  = 3'd4,
        OFS_LINESTAT  = 3'd5,
        OFS_MODEMSTAT = 3'd6,
        OFS_SCRATCH   = 3'd7
    } reg_ofs_e;

    // Line control bit that overlays the divisor on offsets 0 and 1
    localparam int DIV_ACCESS_BIT = 7;

    // Line status bit positions
    localparam int LS_DATA_READY = 0;
    localparam int LS_OVERRUN    = 1;
    localparam int LS_THR_EMPTY  = 5;
    localparam int LS_TX_IDLE    = 6;

    // Value returned by a data read with nothing buffered
    localparam logic [BYTE_W-1:0] EMPTY_READ = 8'hFF;
    // Transmit byte that is swallowed
    localparam logic [BYTE_W-1:0] TX_DROP    = 8'hFF;

    typedef enum logic {
        IDENT_ODD,
        IDENT_EVEN
    } ident_state_e;

endpackage

// File: rtl/srp_rx_fifo.sv
module srp_rx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [WIDTH-1:0]              push_data,
    input  logic                          pop,
    output logic [WIDTH-1:0]              head_data,
    output logic                          full,
    output logic                          empty,
    output logic [$clog2(DEPTH+1)-1:0]    fill
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head_data = mem[rd_ptr];
    assign fill    = count;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/srp_ident_fsm.sv
module srp_ident_fsm
    import serial_port_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ident,
    output logic [BYTE_W-1:0] ident_value
);
    ident_state_e state_q;
    ident_state_e state_d;

    // Next-state logic and state register
    always_comb begin
        state_d = state_q;
        if (rd_ident) begin
            unique case (state_q)
                IDENT_ODD:  state_d = IDENT_EVEN;
                IDENT_EVEN: state_d = IDENT_ODD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDENT_ODD;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            IDENT_ODD:  ident_value = 8'h01;
            IDENT_EVEN: ident_value = 8'h00;
        endcase
    end

endmodule

// File: rtl/srp_tx_stage.sv
module srp_tx_stage
    import serial_port_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hold,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= wr_hold && (wr_data != TX_DROP);
            if (wr_hold) begin
                tx_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
    import serial_port_regs_pkg::*;
#(
    parameter int RX_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int CW = $clog2(RX_DEPTH + 1);

    reg_ofs_e          ofs;
    logic [BYTE_W-1:0] line_ctl_q;
    logic [BYTE_W-1:0] int_en_q;
    logic [BYTE_W-1:0] modem_ctl_q;
    logic [BYTE_W-1:0] scratch_q;
    logic [2*BYTE_W-1:0] divisor_q;
    logic              overrun_q;
    logic              irq_q;
    logic              div_access;
    logic              rx_full;
    logic              rx_empty;
    logic [BYTE_W-1:0] rx_head;
    logic [CW-1:0]     fill_level;
    logic              push_ok;
    logic              push_lost;
    logic              pop_req;
    logic              rd_ident;
    logic              wr_hold;
    logic [BYTE_W-1:0] ident_value;
    logic [BYTE_W-1:0] line_stat;

    assign ofs        = reg_ofs_e'(bus_addr);
    assign div_access = line_ctl_q[DIV_ACCESS_BIT];
    assign rx_ready   = !rx_full;
    assign push_ok    = rx_valid && !rx_full;
    assign push_lost  = rx_valid && rx_full;
    assign pop_req    = bus_rd && (ofs == OFS_HOLD) && !div_access;
    assign rd_ident   = bus_rd && (ofs == OFS_IDENT);
    assign wr_hold    = bus_wr && (ofs == OFS_HOLD) && !div_access;

    srp_rx_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (RX_DEPTH)
    ) rx_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ok),
        .push_data (rx_data),
        .pop       (pop_req),
        .head_data (rx_head),
        .full      (rx_full),
        .empty     (rx_empty),
        .fill      (fill_level)
    );

    srp_ident_fsm ident_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_ident    (rd_ident),
        .ident_value (ident_value)
    );

    srp_tx_stage tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hold  (wr_hold),
        .wr_data  (bus_wdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    // Register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_ctl_q  <= '0;
            int_en_q    <= '0;
            modem_ctl_q <= '0;
            scratch_q   <= '0;
            divisor_q   <= '0;
        end else if (bus_wr) begin
            unique case (ofs)
                OFS_HOLD: begin
                    if (div_access) divisor_q[BYTE_W-1:0] <= bus_wdata;
                end
                OFS_IEN: begin
                    if (div_access) divisor_q[2*BYTE_W-1:BYTE_W] <= bus_wdata;
                    else            int_en_q <= bus_wdata;
                end
                OFS_LINECTL:  line_ctl_q  <= bus_wdata;
                OFS_MODEMCTL: modem_ctl_q <= bus_wdata;
                OFS_SCRATCH:  scratch_q   <= bus_wdata;
                OFS_IDENT, OFS_LINESTAT, OFS_MODEMSTAT: begin
                end
            endcase
        end
    end

    // Sticky overrun and interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (push_lost) begin
                overrun_q <= 1'b1;
            end else if (bus_rd && (ofs == OFS_LINESTAT)) begin
                overrun_q <= 1'b0;
            end
            irq_q <= push_ok && int_en_q[0];
        end
    end

    assign irq = irq_q;

    always_comb begin
        line_stat = '0;
        line_stat[LS_DATA_READY] = !rx_empty;
        line_stat[LS_OVERRUN]    = overrun_q;
        line_stat[LS_THR_EMPTY]  = 1'b1;
        line_stat[LS_TX_IDLE]    = 1'b1;
    end

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (ofs)
                OFS_HOLD: begin
                    if (div_access)    bus_rdata = divisor_q[BYTE_W-1:0];
                    else if (rx_empty) bus_rdata = EMPTY_READ;
                    else               bus_rdata = rx_head;
                end
                OFS_IEN:       bus_rdata = div_access ? divisor_q[2*BYTE_W-1:BYTE_W] : int_en_q;
                OFS_IDENT:     bus_rdata = ident_value;
                OFS_LINECTL:   bus_rdata = line_ctl_q;
                OFS_MODEMCTL:  bus_rdata = modem_ctl_q;
                OFS_LINESTAT:  bus_rdata = line_stat;
                OFS_MODEMSTAT: bus_rdata = '0;
                OFS_SCRATCH:   bus_rdata = scratch_q;
            endcase
        end
    end

endmodule

// File: rtl/serial_port_regs_chk.sv
module serial_port_regs_chk #(
    parameter int RX_DEPTH = 16,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic [2:0]    bus_addr,
    input logic [7:0]    bus_wr_data,
    input logic          bus_wr,
    input logic [7:0]    bus_rdata,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          irq,
    input logic          div_access,
    input logic [CW-1:0] fill_level
);
    logic ident_seen;
    logic ident_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ident_seen <= 1'b0;
            ident_last <= 1'b0;
        end else if (bus_rd && bus_addr == 3'd2) begin
            ident_seen <= 1'b1;
            ident_last <= bus_rdata[0];
        end
    end

    p_lsr_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd5) |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == (fill_level != '0)));

    p_tx_no_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data != 8'hFF));

    p_tx_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($past(bus_wr && bus_addr == 3'd0 && !div_access) && tx_data == $past(bus_wr_data)));

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rx_valid && rx_ready));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(RX_DEPTH));

    p_ready_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> (fill_level == CW'(RX_DEPTH)));

    p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd0 && !div_access && fill_level == '0) |-> (bus_rdata == 8'hFF));

    p_ident_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd2 && ident_seen) |-> (bus_rdata[0] != ident_last && bus_rdata[7:1] == 7'd0));

endmodule

bind serial_port_regs serial_port_regs_chk #(
    .RX_DEPTH (RX_DEPTH),
    .CW       (CW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wr_data (bus_wdata),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .irq         (irq),
    .div_access  (div_access),
    .fill_level  (fill_level)
);

// File: tb/serial_port_regs_tb_top.sv
`timescale 1ns/1ps
module serial_port_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       irq;

    always #2.5 clk = ~clk;

    serial_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;

    // Reference model state
    logic [7:0]  m_lcr = 0, m_ien = 0, m_mcr = 0, m_scr = 0;
    logic [15:0] m_div = 0;
    logic        m_ident = 1'b1;
    logic        m_ovr = 1'b0;
    logic [7:0]  m_q[$];
    logic [7:0]  m_tx[$];

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? "R2" : "R5";
            3'd1: return m_lcr[7] ? "R2" : "R4";
            3'd2: return "R8";
            3'd3: return "R2";
            3'd5: return "R6";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Expected read value; applies the read's side effects to the model
    function automatic logic [7:0] model_read(input logic [2:0] a);
        logic [7:0] v;
        case (a)
            3'd0: if (m_lcr[7]) v = m_div[7:0];
                  else if (m_q.size() == 0) v = 8'hFF;
                  else v = m_q.pop_front();
            3'd1: v = m_lcr[7] ? m_div[15:8] : m_ien;
            3'd2: begin v = {7'd0, m_ident}; m_ident = ~m_ident; end
            3'd3: v = m_lcr;
            3'd4: v = m_mcr;
            3'd5: begin
                v = 8'h60 | {6'd0, m_ovr, (m_q.size() != 0)};
                m_ovr = 1'b0;
            end
            3'd6: v = 8'h00;
            default: v = m_scr;
        endcase
        return v;
    endfunction

    function automatic void model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: if (m_lcr[7]) m_div[7:0] = d; else if (d != 8'hFF) m_tx.push_back(d);
            3'd1: if (m_lcr[7]) m_div[15:8] = d; else m_ien = d;
            3'd3: m_lcr = d;
            3'd4: m_mcr = d;
            3'd7: m_scr = d;
            default: ;
        endcase
    endfunction

    // Transmit stream monitor (R3)
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (m_tx.size() == 0) begin
                check(1'b0, "R3 unexpected tx", {8'd0, tx_data}, 16'h0);
            end else begin
                logic [7:0] e;
                e = m_tx.pop_front();
                check(tx_data == e, "R3 tx byte", {8'd0, tx_data}, {8'd0, e});
            end
        end
    end

    task automatic do_read(input logic [2:0] a);
        logic [7:0] e;
        string t;
        t = tag_for(a);
        bus_rd = 1'b1; bus_addr = a;
        e = model_read(a);
        #1;
        check(bus_rdata == e, t, {8'd0, bus_rdata}, {8'd0, e});
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        model_write(a, d);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_push(input logic [7:0] d);
        logic exp_irq;
        logic acc;
        acc = (m_q.size() < 16);
        rx_valid = 1'b1; rx_data = d;
        #1;
        check(rx_ready == acc, "R7 rx_ready", {15'd0, rx_ready}, {15'd0, acc});
        if (acc) m_q.push_back(d); else m_ovr = 1'b1;
        exp_irq = acc && m_ien[0];
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        check(irq == exp_irq, "R9 irq", {15'd0, irq}, {15'd0, exp_irq});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(rx_ready == 1'b1, "R1 rx_ready", {15'd0, rx_ready}, 16'd1);
        check(tx_valid == 1'b0, "R1 tx_valid", {15'd0, tx_valid}, 16'd0);
        check(irq == 1'b0, "R1 irq", {15'd0, irq}, 16'd0);
        for (int a = 0; a < 8; a++) do_read(3'(a));
        do_write(3'd3, 8'h80);
        do_read(3'd0); do_read(3'd1);

        // R2 divisor overlay
        do_write(3'd0, 8'h34); do_write(3'd1, 8'h12);
        do_read(3'd0); do_read(3'd1); do_read(3'd3);
        do_write(3'd3, 8'h03);
        do_read(3'd1);

        // R3 transmit, 0xFF dropped
        do_write(3'd0, 8'h41); do_write(3'd0, 8'hFF); do_write(3'd0, 8'h0A);

        // R10 ignored writes; R11 plain registers
        do_write(3'd2, 8'hC7); do_write(3'd5, 8'hFF); do_write(3'd6, 8'hAA);
        do_read(3'd2); do_read(3'd5); do_read(3'd6); do_read(3'd2);
        do_write(3'd4, 8'h1F); do_write(3'd7, 8'h5A);
        do_read(3'd4); do_read(3'd7);

        // R5 empty read, R9 irq, R7 overrun
        do_read(3'd0); do_read(3'd5);
        do_write(3'd1, 8'h01);
        for (int i = 0; i < 17; i++) do_push(8'(i * 7 + 3));
        do_read(3'd5); do_read(3'd5);
        do_write(3'd1, 8'h00);
        do_push(8'h99);
        for (int i = 0; i < 17; i++) do_read(3'd0);
        do_read(3'd5);

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            int unsigned op;
            op = $urandom % 10;
            if (op < 4) do_push(8'($urandom));
            else if (op < 7) do_read(3'($urandom % 8));
            else do_write(3'($urandom % 8), ((($urandom % 4) == 0) ? 8'hFF : 8'($urandom)));
        end

        @(negedge clk); @(negedge clk);
        check(m_tx.size() == 0, "R3 pending tx", 16'(m_tx.size()), 16'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule